// File: doc/BRIEF.md
# Searchable Word Store with Miss Flag

This block holds a small array of words in flip-flops. It can be used as a plain RAM: one port writes a word at an address, and a second port reads a word at an address combinationally. It can also be searched. A search strobe with a key compares the key against every stored word at once. On the next clock edge the block returns three things: a vector with one match bit per word, a miss flag that is high only when no word matched, and the index of the lowest-numbered matching word.

Each word has a valid bit. A write sets the valid bit of the word it writes. Reset clears every valid bit, so a freshly reset array cannot match any key. A search never selects a word by address, so it never changes the stored contents. A write and a search may happen in the same cycle. In that case the search compares against the contents as they were before the write. The results stay as they are until the next search strobe.

Top module: `cam_array`

## Requirements
- R1: After a write of data D to address A, a read at address A returns D combinationally from the cycle after the write until the word is written again.
- R2: While reset is asserted, and after it is released, every valid bit is clear. The outputs then show match_vec all zero, miss high, hit_idx zero and srch_done low. A search issued after reset, with no write since, misses for any key.
- R3: One clock after srch_en is sampled high, bit i of match_vec is 1 exactly when word i is valid and its stored value equals srch_key.
- R4: miss is high exactly when every bit of match_vec is zero.
- R5: When miss is low, hit_idx is the lowest i with match_vec[i] set. When miss is high, hit_idx is zero.
- R6: srch_done is high for exactly the one cycle after each cycle in which srch_en is sampled high, and low otherwise.
- R7: A search does not change any stored word or valid bit. Reads taken after a search return the same data as before it.
- R8: When a write and a search are sampled in the same cycle, the search result reflects the contents before that write.
- R9: In cycles after srch_en is sampled low, match_vec, miss and hit_idx keep their previous values.
- R10: When several valid words equal the key, all of their match bits are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears valid bits and result registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | WIDTH | Word at rd_addr (combinational) |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Key compared against all words |
| match_vec | output | DEPTH | Registered per-word match bits |
| miss | output | 1 | Registered; high when no word matched |
| hit_idx | output | $clog2(DEPTH) | Registered lowest matching index; zero on miss |
| srch_done | output | 1 | One-cycle pulse marking new search results |

## Verification
The assertions assume three things about the inputs. Addresses stay below DEPTH. Strobes are known values on every sampled edge. rst_n is held low for at least one edge before any checked activity. The bench drives all inputs on the falling edge, from reset onward, and takes addresses only from the range 0 to DEPTH-1. Random keys and data come from a narrow set of values, so that hits, multi-hits and misses all occur often. The read-after-write property also assumes that a read of a word nobody has written is not compared. For that reason the bench compares read data only for words its model holds as valid.

// File: rtl/cam_array.sv
module cam_array #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] srch_key,
  output logic [DEPTH-1:0] match_vec,
  output logic             miss,
  output logic [AW-1:0]    hit_idx,
  output logic             srch_done
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] hit;
  logic [AW-1:0]    first;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n)     valid <= '0;
    else if (wr_en) valid[wr_addr] <= 1'b1;

  assign rd_data = mem[rd_addr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = valid[i] && (mem[i] == srch_key);
  end

  always_comb begin
    first = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i]) first = AW'(i);
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      match_vec <= '0;
      miss      <= 1'b1;
      hit_idx   <= '0;
      srch_done <= 1'b0;
    end else begin
      srch_done <= srch_en;
      if (srch_en) begin
        match_vec <= hit;
        miss      <= ~|hit;
        hit_idx   <= first;
      end
    end

endmodule

// File: rtl/cam_array_chk.sv
module cam_array_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             srch_en,
  input logic [DEPTH-1:0] match_vec,
  input logic             miss,
  input logic [AW-1:0]    hit_idx,
  input logic             srch_done
);

  logic [DEPTH-1:0] sel, below;
  assign sel   = {{(DEPTH-1){1'b0}}, 1'b1} << hit_idx;
  assign below = sel - 1'b1;

  p_read_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));

  p_reset_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (match_vec == '0) && miss && !srch_done && (hit_idx == '0));

  p_miss_nor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss == (match_vec == '0));

  p_lowest_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |-> ((match_vec & sel) != '0) && ((match_vec & below) == '0));

  p_idx_zero_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> hit_idx == '0);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> srch_done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !srch_done);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> $stable(match_vec) && $stable(miss) && $stable(hit_idx));

endmodule

bind cam_array cam_array_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .srch_en(srch_en), .match_vec(match_vec), .miss(miss),
  .hit_idx(hit_idx), .srch_done(srch_done)
);

// File: tb/cam_array_test.sv
module cam_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, wr_en, srch_en;
  logic [AW-1:0] wr_addr, rd_addr, hit_idx;
  logic [WIDTH-1:0] wr_data, rd_data, srch_key;
  logic [DEPTH-1:0] match_vec;
  logic miss, srch_done;

  int checks = 0, fails = 0;

  logic [WIDTH-1:0] ref_mem [DEPTH];
  logic [DEPTH-1:0] ref_valid;
  logic [DEPTH-1:0] e_match;
  logic e_miss, e_done;
  logic [AW-1:0] e_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(match_vec === e_match, "R3 match_vec", 32'(match_vec), 32'(e_match));
    chk(miss === e_miss, "R4 miss", 32'(miss), 32'(e_miss));
    chk(hit_idx === e_idx, "R5 hit_idx", 32'(hit_idx), 32'(e_idx));
    chk(srch_done === e_done, "R6 srch_done", 32'(srch_done), 32'(e_done));
    if (ref_valid[rd_addr])
      chk(rd_data === ref_mem[rd_addr], "R1 rd_data", 32'(rd_data), 32'(ref_mem[rd_addr]));
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      ref_valid = '0; e_match = '0; e_miss = 1'b1; e_idx = '0; e_done = 1'b0;
    end else begin
      e_done = srch_en;
      if (srch_en) begin
        for (int i = 0; i < DEPTH; i++)
          e_match[i] = ref_valid[i] && (ref_mem[i] == srch_key);
        e_miss = (e_match == '0);
        e_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
          if (e_match[i]) e_idx = AW'(i);
      end
    end
    if (wr_en) begin
      ref_mem[wr_addr] = wr_data;
      if (rst_n) ref_valid[wr_addr] = 1'b1;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wr_en = 0; srch_en = 0; step();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = WIDTH'(d); rd_addr = AW'(a); srch_en = 0;
    step(); wr_en = 0;
  endtask

  task automatic srch(input int k);
    srch_en = 1; srch_key = WIDTH'(k); wr_en = 0;
    step(); srch_en = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; wr_en = 0; srch_en = 0; wr_addr = '0; rd_addr = '0;
    wr_data = '0; srch_key = '0;
    @(negedge clk);
    step(); step();
    rst_n = 1;
    idle();
    // R2: reset state and a search of an empty array
    chk(miss === 1'b1 && match_vec === '0 && !srch_done, "R2 reset state", 32'(match_vec), 0);
    srch(0);
    chk(miss === 1'b1, "R2 empty search misses", 32'(miss), 1);

    // R1: fill and read back
    for (int a = 0; a < DEPTH; a++) wr(a, a * 7 + 3);
    for (int a = 0; a < DEPTH; a++) begin rd_addr = AW'(a); idle(); end

    // R3 single hit
    srch(5 * 7 + 3);
    chk(match_vec === DEPTH'(1 << 5) && hit_idx === AW'(5), "R3 single hit word 5", 32'(match_vec), 32'(1 << 5));

    // R10 multi hit, R5 lowest index
    wr(9, 2 * 7 + 3);
    wr(14, 2 * 7 + 3);
    srch(2 * 7 + 3);
    chk(match_vec === DEPTH'((1 << 2) | (1 << 9) | (1 << 14)), "R10 multi-hot", 32'(match_vec), 32'((1 << 2) | (1 << 9) | (1 << 14)));
    chk(hit_idx === AW'(2), "R5 lowest of several", 32'(hit_idx), 2);

    // R4 miss on absent key
    srch(8'hFF);
    chk(miss === 1'b1 && match_vec === '0, "R4 absent key", 32'(miss), 1);

    // R9 hold
    srch(5 * 7 + 3);
    idle(); idle();
    chk(match_vec === DEPTH'(1 << 5) && !srch_done, "R9 results held", 32'(match_vec), 32'(1 << 5));

    // R8 write and search together
    srch_en = 1; srch_key = 8'hA5; wr_en = 1; wr_addr = AW'(12); wr_data = 8'hA5; rd_addr = AW'(12);
    step(); srch_en = 0; wr_en = 0;
    chk(miss === 1'b1, "R8 search sees old contents", 32'(miss), 1);
    srch(8'hA5);
    chk(match_vec === DEPTH'(1 << 12), "R8 next search sees write", 32'(match_vec), 32'(1 << 12));

    // R7 contents unchanged by searches
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a); idle();
      chk(rd_data === ref_mem[a], "R7 contents after searches", 32'(rd_data), 32'(ref_mem[a]));
    end

    // R2 reset mid-run clears valid bits
    rst_n = 0; step(); rst_n = 1; idle();
    srch(8'hA5);
    chk(miss === 1'b1, "R2 valid cleared by reset", 32'(miss), 1);

    // random traffic, narrow value set
    for (int n = 0; n < 2000; n++) begin
      wr_en = ($urandom_range(0, 2) == 0);
      srch_en = ($urandom_range(0, 1) == 0);
      wr_addr = AW'($urandom_range(0, DEPTH - 1));
      rd_addr = AW'($urandom_range(0, DEPTH - 1));
      wr_data = WIDTH'($urandom_range(0, 5));
      srch_key = WIDTH'($urandom_range(0, 6));
      step();
    end
    wr_en = 0; srch_en = 0;
    idle();
    finish_up();
  end
endmodule